// File: doc/BRIEF.md
# Programmable Chip-Select Unit with Wait-State Acknowledge

This block sits between a processor's external bus and a set of memory and peripheral devices. It decodes the upper half of each bus address against a base and mask pair per select line. It drives exactly one select line for the duration of a bus cycle. It then ends the cycle with a single-clock transfer acknowledge. For each select, the acknowledge comes from one of two sources. The first is an internal counter that waits a programmed number of clocks, which serves devices such as boot flash that cannot answer by themselves. The second is the addressed device itself, through an external acknowledge input.

After reset, select zero answers every address. This lets a processor fetch its first words from a boot memory sitting at address zero. Boot code then programs the bases, masks and timing, and can relocate the boot memory to a high region such as 0xFFE0_0000. The first write to select zero's mask register ends the catch-all behaviour. An access that hits nothing is closed by a bus-timeout pulse rather than hanging the bus.

Configuration arrives through a write-only register port. The address on that port is formed from the select number and a field code.

Top module: `chip_select_unit`

## Requirements
- R1: While reset is held and in the first clock after it, `sel`, `ta` and `timeout` are all low.
- R2: From reset until select zero's mask register is written, every started cycle asserts `sel[0]`, whatever the address and whatever the other selects hold.
- R3: Once select zero's mask register has been written, select zero asserts only for addresses in its base/mask range, and only if the written valid bit is 1.
- R4: A select matches when address bits 31..16 equal its base in every position where its mask bit is 0; address bits 15..0 never affect decoding.
- R5: A select whose valid bit (mask register bit 0) is 0 never asserts, apart from select zero under R2.
- R6: When several selects match, only the lowest-numbered one is asserted; `sel` is never more than one-hot.
- R7: With auto-acknowledge on and a wait count N (0..15), `ta` goes high N clock edges after the edge that samples `bus_start`. For N=0, this is the select's first clock, and for N=6 it is the seventh.
- R8: With auto-acknowledge off, `ta` follows `ext_ack` in the same clock while a cycle is open. `ext_ack` has no effect when no cycle is open, and no effect on a select in auto-acknowledge mode.
- R9: `ta` is one clock wide. In the next clock `sel` is low, and a new cycle started after that counts its wait states from zero.
- R10: A cycle that matches no valid select asserts no select and gets no internal acknowledge. If nothing answers, `timeout` pulses for one clock during the 256th clock of the open cycle, and the cycle closes.
- R11: `bus_start` pulses while a cycle is open (including its acknowledge clock) are ignored. They do not change `sel` or the acknowledge clock.
- R12: The register address is {select number, field[1:0]}. Field 0 holds the base in data bits 31..16. Field 1 holds the mask in bits 31..16 and the valid bit in bit 0. Field 2 holds the wait count in bits 3..0 and auto-acknowledge enable in bit 4. Writes to field 3 change nothing. At reset each control field holds wait count 15 with auto-acknowledge on, and every valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {select number, field code} |
| reg_wdata | input | 32 | Register write data |
| bus_addr | input | 32 | Bus address, sampled with `bus_start` |
| bus_start | input | 1 | Cycle start strobe |
| ext_ack | input | 1 | Acknowledge from the addressed device |
| sel | output | 4 | One-hot select outputs |
| ta | output | 1 | Transfer acknowledge pulse |
| timeout | output | 1 | Bus-timeout pulse |

## Verification
The first addresses tried are all-zero, all-one and arbitrary, sent while the unit is still in its reset state. These show whether the catch-all select ends only on the mask write and not on a base or control write. Overlapping ranges, a matching select with its valid bit clear, and addresses whose low half varies at random separate priority from plain matching, and show that the low address bits are ignored. Timing is tested with wait counts of 0, 6 and 15 and with external acknowledges at varied delays, some raised too early in auto mode or while idle. Back-to-back cycles and mid-cycle start strobes show whether the counter restarts cleanly and whether a second strobe can re-decode. A seeded random phase then mixes configuration writes with accesses and compares each select, acknowledge clock and timeout against a bench model.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int ADDR_W = 32;
  localparam int CMP_LO = 16;
  localparam int CMP_W  = ADDR_W - CMP_LO;
  localparam int WS_W   = 4;
  localparam int DATA_W = 32;

  // field codes on the register port
  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_MASK = 2'd1;
  localparam logic [1:0] FLD_CTRL = 2'd2;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] mask;
    logic             valid;
    logic             auto_ack;
    logic [WS_W-1:0]  ws;
  } sel_cfg_t;

  // compare only where the mask bit is clear
  function automatic logic range_hit(logic [CMP_W-1:0] a_hi,
                                     logic [CMP_W-1:0] base,
                                     logic [CMP_W-1:0] mask);
    return ((a_hi ^ base) & ~mask) == '0;
  endfunction

endpackage

// File: rtl/bsu_regs.sv
module bsu_regs
  import bsu_pkg::*;
#(
  parameter int NUM_SEL = 4,
  localparam int IDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int RA_W  = IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output sel_cfg_t [NUM_SEL-1:0]   cfg,
  output logic                     global0
);

  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_fld;
  logic             mask0_wr;
  logic             unused_wdata;

  assign wr_idx       = reg_addr[RA_W-1:2];
  assign wr_fld       = reg_addr[1:0];
  assign mask0_wr     = reg_we && (wr_idx == '0) && (wr_fld == FLD_MASK);
  assign unused_wdata = ^reg_wdata[CMP_LO-1:WS_W+1];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    logic hit_me;
    assign hit_me = reg_we && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i].base     <= '0;
        cfg[i].mask     <= '0;
        cfg[i].valid    <= 1'b0;
        cfg[i].auto_ack <= 1'b1;
        cfg[i].ws       <= '1;
      end else if (hit_me) begin
        case (wr_fld)
          FLD_BASE: cfg[i].base <= reg_wdata[DATA_W-1:CMP_LO];
          FLD_MASK: begin
            cfg[i].mask  <= reg_wdata[DATA_W-1:CMP_LO];
            cfg[i].valid <= reg_wdata[0];
          end
          FLD_CTRL: begin
            cfg[i].ws       <= reg_wdata[WS_W-1:0];
            cfg[i].auto_ack <= reg_wdata[WS_W];
          end
          default: ;
        endcase
      end
    end
  end

  // catch-all state of select zero, ended by its first mask write
  always_ff @(posedge clk) begin
    if (!rst_n)        global0 <= 1'b1;
    else if (mask0_wr) global0 <= 1'b0;
  end

  a_r2_global_ends_on_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mask0_wr |=> !global0);
  a_r2_global_never_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !global0 |=> !global0);
  a_r2_global_kept_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (global0 && !mask0_wr) |=> global0);

endmodule

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int NUM_SEL = 4
) (
  input  logic [CMP_W-1:0]         addr_hi,
  input  sel_cfg_t [NUM_SEL-1:0]   cfg,
  input  logic                     global0,
  output logic [NUM_SEL-1:0]       raw_hit,
  output logic [NUM_SEL-1:0]       grant,
  output logic                     win_auto,
  output logic [WS_W-1:0]          win_ws
);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_match
    logic in_range;
    assign in_range = cfg[i].valid && range_hit(addr_hi, cfg[i].base, cfg[i].mask);
    if (i == 0) begin : g_zero
      assign raw_hit[i] = in_range || global0;
    end else begin : g_rest
      assign raw_hit[i] = in_range;
    end
  end

  // lowest-numbered hit wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (raw_hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // timing of the winner; no winner means no internal acknowledge
  always_comb begin
    win_auto = 1'b0;
    win_ws   = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (grant[i]) begin
        win_auto = cfg[i].auto_ack;
        win_ws   = cfg[i].ws;
      end
    end
  end

endmodule

// File: rtl/bsu_cycle.sv
module bsu_cycle
  import bsu_pkg::*;
#(
  parameter int NUM_SEL      = 4,
  parameter int TIMEOUT_CLKS = 256,
  localparam int AGE_W = (TIMEOUT_CLKS > 16) ? $clog2(TIMEOUT_CLKS) : WS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_start,
  input  logic                ext_ack,
  input  logic [NUM_SEL-1:0]  grant,
  input  logic                win_auto,
  input  logic [WS_W-1:0]     win_ws,
  output logic [NUM_SEL-1:0]  sel,
  output logic                ta,
  output logic                timeout
);

  logic               busy;
  logic               auto_q;
  logic [WS_W-1:0]    ws_q;
  logic [AGE_W-1:0]   age;

  // named events for the assertions
  logic cyc_open, ack_int, ack_ext, expire, cyc_close;

  function automatic logic wait_done(logic [AGE_W-1:0] cur, logic [WS_W-1:0] limit);
    return cur == AGE_W'(limit);
  endfunction

  function automatic logic age_limit(logic [AGE_W-1:0] cur);
    return cur == AGE_W'(TIMEOUT_CLKS - 1);
  endfunction

  assign cyc_open  = bus_start && !busy;
  assign ack_int   = busy && auto_q && wait_done(age, ws_q);
  assign ack_ext   = busy && !auto_q && ext_ack;
  assign ta        = ack_int || ack_ext;
  assign expire    = busy && !ta && age_limit(age);
  assign timeout   = expire;
  assign cyc_close = ta || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sel    <= '0;
      auto_q <= 1'b0;
      ws_q   <= '0;
      age    <= '0;
    end else if (cyc_open) begin
      busy   <= 1'b1;
      sel    <= grant;
      auto_q <= win_auto;
      ws_q   <= win_ws;
      age    <= '0;
    end else if (busy) begin
      if (cyc_close) begin
        busy <= 1'b0;
        sel  <= '0;
        age  <= '0;
      end else begin
        age  <= age + AGE_W'(1);
      end
    end
  end

  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> !ta);
  a_r9_sel_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> (sel == '0));
  a_r11_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_close) |=> (busy && $stable(sel)));
  a_r10_no_internal_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sel == '0) && ta) |-> ext_ack);
  a_r10_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!ta && busy));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ta && !timeout && sel == '0));

endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
  import bsu_pkg::*;
#(
  parameter int NUM_SEL      = 4,
  parameter int TIMEOUT_CLKS = 256,
  localparam int IDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int RA_W  = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_start,
  input  logic                ext_ack,
  output logic [NUM_SEL-1:0]  sel,
  output logic                ta,
  output logic                timeout
);

  sel_cfg_t [NUM_SEL-1:0] cfg;
  logic                   global0;
  logic [NUM_SEL-1:0]     raw_hit;
  logic [NUM_SEL-1:0]     grant;
  logic                   win_auto;
  logic [WS_W-1:0]        win_ws;
  logic                   unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[CMP_LO-1:0];

  bsu_regs #(.NUM_SEL(NUM_SEL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg       (cfg),
    .global0   (global0)
  );

  bsu_decode #(.NUM_SEL(NUM_SEL)) u_decode (
    .addr_hi  (bus_addr[ADDR_W-1:CMP_LO]),
    .cfg      (cfg),
    .global0  (global0),
    .raw_hit  (raw_hit),
    .grant    (grant),
    .win_auto (win_auto),
    .win_ws   (win_ws)
  );

  bsu_cycle #(.NUM_SEL(NUM_SEL), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .ext_ack   (ext_ack),
    .grant     (grant),
    .win_auto  (win_auto),
    .win_ws    (win_ws),
    .sel       (sel),
    .ta        (ta),
    .timeout   (timeout)
  );

  // R6: the grant is a subset of the raw hits, at most one bit
  a_r6_grant_from_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~raw_hit) == '0) && $onehot0(grant));
  // R2: catch-all select zero wins any started cycle
  a_r2_global_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (global0 && bus_start && sel == '0 && !ta && !timeout) |=> sel[0]);

endmodule

// File: tb/chip_select_unit_bench.sv
module chip_select_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int TO = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] bus_addr;
  logic        bus_start;
  logic        ext_ack;
  logic [NS-1:0] sel;
  logic        ta;
  logic        timeout;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_select_unit u_chip_select_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_addr(bus_addr), .bus_start(bus_start),
    .ext_ack(ext_ack), .sel(sel), .ta(ta), .timeout(timeout)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model of the programmed state
  logic [15:0] m_base [NS];
  logic [15:0] m_mask [NS];
  logic        m_valid[NS];
  logic        m_auto [NS];
  logic [3:0]  m_ws   [NS];
  logic        m_g0;

  task automatic check(string req, logic ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  function automatic int exp_idx(logic [31:0] a);
    for (int i = 0; i < NS; i++) begin
      if ((i == 0 && m_g0) ||
          (m_valid[i] && (((a[31:16] ^ m_base[i]) & ~m_mask[i]) == 16'h0)))
        return i;
    end
    return -1;
  endfunction

  task automatic wreg(int idx, int fld, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = {idx[1:0], fld[1:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (fld)
      0: m_base[idx] = d[31:16];
      1: begin m_mask[idx] = d[31:16]; m_valid[idx] = d[0]; if (idx == 0) m_g0 = 1'b0; end
      2: begin m_ws[idx] = d[3:0]; m_auto[idx] = d[4]; end
      default: ;
    endcase
  endtask

  // one access; ext_at / again_at count clocks from the select's first clock
  task automatic bus_cycle(string req, logic [31:0] a, int ext_at, int again_at);
    int ei;
    int exp_k;
    int got_k;
    logic exp_to;
    logic got_to;
    logic [NS-1:0] s0;
    logic [NS-1:0] exp_sel;
    logic moved;
    ei = exp_idx(a);
    exp_sel = (ei >= 0) ? NS'(1 << ei) : '0;
    if (ei >= 0 && m_auto[ei]) begin exp_k = m_ws[ei]; exp_to = 1'b0; end
    else if (ext_at >= 0 && ext_at < TO - 1) begin exp_k = ext_at; exp_to = 1'b0; end
    else begin exp_k = TO - 1; exp_to = 1'b1; end
    got_k = -1; got_to = 1'b0; moved = 1'b0;
    @(negedge clk);
    bus_addr = a; bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
    s0 = sel;
    for (int k = 0; k < TO + 4; k++) begin
      if (k == again_at) begin bus_start = 1'b1; bus_addr = ~a; end
      if (k == ext_at) ext_ack = 1'b1;
      #1;
      if (sel !== s0) moved = 1'b1;
      if (ta === 1'b1 || timeout === 1'b1) begin got_k = k; got_to = timeout; break; end
      @(negedge clk);
      bus_start = 1'b0; ext_ack = 1'b0;
    end
    @(negedge clk);
    bus_start = 1'b0; ext_ack = 1'b0;
    #1;
    check(req, s0 == exp_sel, "select", int'(s0), int'(exp_sel));
    check(req, got_k == exp_k, "ack clock", got_k, exp_k);
    check("R10", got_to == exp_to, "timeout", int'(got_to), int'(exp_to));
    check((again_at >= 0) ? "R11" : req, !moved, "select moved", int'(moved), 0);
    check("R9", sel == '0 && ta == 1'b0, "after ack", int'({sel, ta}), 0);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'hC5E1_0D1E);
    for (int i = 0; i < NS; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_valid[i] = 1'b0; m_auto[i] = 1'b1; m_ws[i] = 4'hF;
    end
    m_g0 = 1'b1;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_addr = '0; bus_start = 1'b0; ext_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", sel == '0 && !ta && !timeout, "outputs in reset", int'({sel, ta, timeout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sel == '0 && !ta && !timeout, "outputs after reset", int'({sel, ta, timeout}), 0);

    // R2 and R12 reset control: catch-all with 15 wait states
    bus_cycle("R2", 32'h0000_0000, -1, -1);
    bus_cycle("R2", 32'hFFFF_FFFF, -1, -1);
    wreg(1, 0, 32'h1234_0000);
    wreg(1, 1, 32'h0000_0001);
    wreg(0, 0, 32'h1234_0000);
    bus_cycle("R2", 32'h1234_5678, -1, -1);
    wreg(0, 2, 32'h0000_0016);            // R7: ws 6, auto on
    bus_cycle("R7", 32'h8765_4321, -1, -1);

    // R3: relocate select zero to the high boot region
    wreg(0, 0, 32'hFFE0_0000);
    wreg(0, 1, 32'h001F_0001);
    bus_cycle("R3", 32'hFFE0_1234, -1, -1);
    bus_cycle("R3", 32'hFFFF_0000, -1, -1);
    bus_cycle("R10", 32'h0000_0000, -1, -1);   // no match, no ack: timeout
    bus_cycle("R4", 32'h1234_ABCD, 40, -1);    // select 1, low half ignored

    // R7 zero wait states, R9 back to back
    wreg(0, 2, 32'h0000_0010);
    bus_cycle("R7", 32'hFFE3_0000, -1, -1);
    wreg(1, 2, 32'h0000_001F);
    bus_cycle("R9", 32'h1234_0000, -1, -1);
    bus_cycle("R9", 32'h1234_FFFF, -1, -1);

    // R8: external acknowledge mode and ignored acknowledges
    wreg(1, 2, 32'h0000_0000);
    bus_cycle("R8", 32'h1234_0001, 9, -1);
    bus_cycle("R8", 32'h1234_0002, 0, -1);
    wreg(0, 2, 32'h0000_0015);
    bus_cycle("R8", 32'hFFE0_0000, 1, -1);     // auto select ignores early ext_ack
    @(negedge clk); ext_ack = 1'b1; #1;
    check("R8", ta == 1'b0 && sel == '0, "idle ext_ack", int'(ta), 0);
    @(negedge clk); ext_ack = 1'b0;

    // R5: valid bit clear never asserts
    wreg(2, 0, 32'h5000_0000);
    wreg(2, 1, 32'h0000_0000);
    bus_cycle("R5", 32'h5000_0000, 12, -1);
    wreg(0, 1, 32'h001F_0000);
    bus_cycle("R5", 32'hFFE0_0000, 7, -1);

    // R6: overlap of selects 1 and 3, and 2 and 3
    wreg(3, 0, 32'h1200_0000);
    wreg(3, 1, 32'h00FF_0001);
    wreg(3, 2, 32'h0000_0013);
    bus_cycle("R6", 32'h1234_0000, 5, -1);
    bus_cycle("R6", 32'h1299_0000, -1, -1);
    wreg(2, 1, 32'h0000_0001);
    wreg(2, 0, 32'h1277_0000);
    wreg(2, 2, 32'h0000_0018);
    bus_cycle("R6", 32'h1277_0000, -1, -1);

    // R12: field 3 writes change nothing
    wreg(2, 3, 32'hFFFF_FFFF);
    bus_cycle("R12", 32'h1277_0000, -1, -1);

    // R11: restart strobe during open cycles
    bus_cycle("R11", 32'h1277_0000, -1, 2);
    bus_cycle("R11", 32'h1277_0000, -1, 8);
    bus_cycle("R11", 32'h1234_0000, 6, 3);

    // random phase
    for (int it = 0; it < 60; it++) begin
      int idx;
      int fld;
      int j;
      int ext_at;
      logic [31:0] a;
      idx = int'($urandom % NS);
      fld = int'($urandom % 3);
      case (fld)
        0: wreg(idx, 0, {$urandom(), 16'h0} & 32'hFFFF_0000);
        1: wreg(idx, 1, (($urandom() & 32'h0F0F_0000)) | {31'h0, ($urandom % 4) != 0});
        default: wreg(idx, 2, {27'h0, ($urandom % 4) != 0, 4'($urandom)});
      endcase
      j = int'($urandom % NS);
      a = $urandom();
      if ($urandom % 4 != 0) a[31:16] = m_base[j] ^ (16'($urandom()) & m_mask[j]);
      ext_at = ($urandom % 8 == 0) ? -1 : int'($urandom % 20);
      bus_cycle("R4", a, ext_at, -1);
    end

    summary();
  end

endmodule